// File: doc/BRIEF.md
# Circular Sample FIFO with Fill-Threshold Interrupt

This block is an eight-slot ring buffer. A streaming producer fills it and a microprocessor drains it. The producer presents one sample per cycle together with a valid strobe. The reader pulses a read strobe and collects one sample per strobe, registered, on the following cycle.

The write and read pointers are kept one step apart. The read pointer rests on the slot *before* the next unread sample, so the two pointers are never equal.

- The distance `write - read` (mod 8) is exported as the fill measure.
- A distance of 1 means empty and a distance of 7 means full, which leaves six usable slots.
- A 3-bit threshold sets when the buffer counts as ready. A single-cycle interrupt marks the moment the fill measure first climbs past that threshold. This lets the reader service the buffer in batches instead of polling every sample.

Writes into a full buffer are dropped and never overwrite stored data. Reads from an empty buffer leave the read pointer where it is.

Top module: `ring_fifo_irq`

## Requirements
- R1: After reset the fill measure `level` is 1, `empty` is 1, `full` is 0, `irq` is 0, and `rd_data` is 0. The write pointer starts at 0 and the read pointer starts at 7.
- R2: `level` equals (write pointer - read pointer) mod 8. `empty` is 1 exactly when `level` is 1, and `full` is 1 exactly when `level` is 7. Six samples fit.
- R3: A write strobe while `full` is 1 stores nothing and leaves `level` unchanged. The samples already held are later read back unaltered.
- R4: A read strobe while `empty` is 1 does not move the read pointer, and `rd_data` keeps its previous value.
- R5: Samples come out in the order they were accepted. `rd_data` shows the sample on the cycle after the accepted read strobe and holds its value when no read is accepted.
- R6: A read and a write in the same cycle are both performed. Each is blocked only by the `full` or `empty` state from before that cycle, so a write while full is still dropped when a read frees a slot in the same cycle.
- R7: `ready` is 1 exactly while `level` is greater than `thresh`.
- R8: `irq` is high for one cycle, the cycle right after an edge at which `level` stepped from `thresh` to `thresh+1`. With `thresh` at 0 or 7 it never fires.
- R9: The two pointers are never equal, so `level` is never 0 under any sequence of strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Producer valid strobe |
| wr_data | input | DW | Sample to store |
| rd_en | input | 1 | Reader strobe |
| thresh | input | PW | Fill threshold for ready and interrupt |
| rd_data | output | DW | Registered read sample |
| full | output | 1 | Fill measure is 7 |
| empty | output | 1 | Fill measure is 1 |
| ready | output | 1 | Fill measure above threshold |
| irq | output | 1 | One-cycle threshold-crossing pulse |
| level | output | PW | Pointer difference, write minus read |

## Verification
The bench drives writes into a full buffer and reads from an empty one. A design that blocked on the wrong distance would either overwrite the oldest sample, which shows up as a wrong value on readback, or let the pointers meet and show a level of 0.

Simultaneous read and write strobes are placed exactly at the empty and full edges. This catches a design that judges blocking on the post-update state and so takes a sample into an already full buffer.

The threshold is swept across its range while the level oscillates around it. A design that raised the interrupt as a level, rather than a pulse, would be caught. So would one that fired on a decrement or on simultaneous read and write, or one that fired at a threshold of 0 or 7.

// File: rtl/ring_fifo_irq.sv
module ring_fifo_irq #(
  parameter int DW = 16,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [PW-1:0] thresh,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic          ready,
  output logic          irq,
  output logic [PW-1:0] level
);
  localparam int N = 1 << PW;
  localparam logic [PW-1:0] ONE = PW'(1);
  localparam logic [PW-1:0] TOP = {PW{1'b1}};

  logic [DW-1:0] mem [N];
  logic [PW-1:0] wp, rp;
  logic          take_wr, take_rd;

  assign level   = wp - rp;
  assign empty   = (level == ONE);
  assign full    = (level == TOP);
  assign ready   = (level > thresh);
  assign take_wr = wr_en && !full;
  assign take_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (take_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= TOP;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (take_wr) wp <= wp + ONE;
      if (take_rd) begin
        rp      <= rp + ONE;
        rd_data <= mem[rp + ONE];
      end
      irq <= take_wr && !take_rd && (level == thresh) && (thresh != TOP);
    end
  end
endmodule

module ring_fifo_irq_chk #(
  parameter int DW = 16,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [PW-1:0] thresh,
  input logic [DW-1:0] rd_data,
  input logic          full,
  input logic          empty,
  input logic          ready,
  input logic          irq,
  input logic [PW-1:0] level
);
  a_r9_ptrs_apart: assert property (@(posedge clk) disable iff (!rst_n)
    level != '0);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> full);
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> (empty && $stable(rd_data)));
  a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r8_irq_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !full && level == thresh && thresh != '1) |=> irq);
  a_r2_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

bind ring_fifo_irq ring_fifo_irq_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .thresh(thresh),
  .rd_data(rd_data), .full(full), .empty(empty), .ready(ready),
  .irq(irq), .level(level)
);

// File: tb/ring_fifo_irq_bench.sv
module ring_fifo_irq_bench;
  localparam int DW = 16;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [PW-1:0] thresh = '0;
  logic [DW-1:0] rd_data;
  logic          full, empty, ready, irq;
  logic [PW-1:0] level;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_rd = '0;
  bit            exp_irq = 0;

  always #2 clk = ~clk;

  ring_fifo_irq #(.DW(DW), .PW(PW)) u_ring_fifo_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .thresh(thresh), .rd_data(rd_data), .full(full),
    .empty(empty), .ready(ready), .irq(irq), .level(level)
  );

  function automatic int exp_level();
    return q.size() + 1;
  endfunction

  function automatic bit exp_ready(input int t);
    return exp_level() > t;
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    cmp({tag, "/R2 level"}, level, exp_level());
    cmp({tag, "/R2 empty"}, empty, exp_level() == 1);
    cmp({tag, "/R2 full"}, full, exp_level() == 7);
    cmp({tag, "/R5 rd_data"}, rd_data, exp_rd);
    cmp({tag, "/R7 ready"}, ready, exp_ready(thresh));
    cmp({tag, "/R8 irq"}, irq, exp_irq);
    cmp({tag, "/R9 ptrs"}, level != 0, 1);
  endtask

  task automatic step(input bit w, input logic [DW-1:0] d, input bit r,
                      input string tag);
    bit fl, em, dw, dr;
    int lv;
    wr_en = w; wr_data = d; rd_en = r;
    lv = exp_level();
    fl = (lv == 7);
    em = (lv == 1);
    dw = w && !fl;
    dr = r && !em;
    exp_irq = dw && !dr && (lv == int'(thresh)) && (thresh != 3'd7);
    if (dr) exp_rd = q.pop_front();
    if (dw) q.push_back(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    cmp("R1 level", level, 1);
    cmp("R1 empty", empty, 1);
    cmp("R1 full", full, 0);
    cmp("R1 irq", irq, 0);
    cmp("R1 rd_data", rd_data, 0);
    rst_n = 1;
    @(negedge clk);
    thresh = 3'd0;

    for (int i = 0; i < 9; i++) step(1, 16'hA000 + 16'(i), 0, "R3 fill");
    cmp("R3 full held", full, 1);
    step(1, 16'hDEAD, 1, "R6 rw at full");
    step(1, 16'hBEEF, 0, "R3 refill");
    for (int i = 0; i < 8; i++) step(0, '0, 1, "R4 drain");
    cmp("R4 empty held", empty, 1);
    step(1, 16'h1234, 1, "R6 rw at empty");
    step(0, '0, 1, "R6 read back");

    for (int t = 0; t < 8; t++) begin
      thresh = 3'(t);
      for (int i = 0; i < 7; i++) step(1, 16'(t * 16 + i), 0, "R8 sweep up");
      for (int i = 0; i < 3; i++) step(0, '0, 1, "R8 sweep down");
      for (int i = 0; i < 3; i++) step(1, 16'(i), 0, "R8 recross");
      for (int i = 0; i < 7; i++) step(0, '0, 1, "R8 empty out");
    end

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 63) == 0) thresh = 3'($urandom_range(0, 7));
      step(1'($urandom_range(0, 1)), 16'($urandom), 1'($urandom_range(0, 1)),
           "R5 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule